// File: doc/BRIEF.md
# Mixed-Sign Multi-Precision Multiply-Accumulate Unit

This block multiplies a 16-bit signed value by a 32-bit signed value with a single shared 16x16 multiplier. The wide operand is split into halves. The lower half carries no sign of its own, so it is multiplied with the narrow operand in a signed-by-unsigned mode. The upper half is multiplied in the ordinary signed-by-signed mode. The lower partial product comes first: it is shifted right arithmetically by one half-word so that it lines up with the upper product, and then the upper product is added on top.

The result lives in a 36-bit accumulator. The bits above the 32-bit product range act as sign-extension guard bits, so a run of accumulations can grow past 32 bits and wraps only modulo 2^36. A mode input, sampled together with the start pulse, chooses one of two operations: start from a cleared result, or add the new product to whatever the accumulator already holds. A single-cycle done strobe marks the end of each operation. The accumulator then keeps its value until the next operation changes it.

Top module: `mixmul_acc`

## Requirements
- R1: While reset is active and after it is released, `acc` is 0 and `done` is 0.
- R2: With `accumMode`=0 the final `acc` equals opA*H + floor(opA*L / 65536), sign-extended to 36 bits. Here opA is signed, H = opB[31:16] is signed and L = opB[15:0] is unsigned.
- R3: The low half opB[15:0] is taken as unsigned, so a set bit 15 adds +32768 and not -32768. Example: opA=2, opB=0x0000_8000 gives acc=1.
- R4: The low partial product is shifted right arithmetically by 16, which rounds it toward minus infinity, before the high product is added. Example: opA=-1, opB=1 gives acc=0xF_FFFF_FFFF.
- R5: With `accumMode`=1 the final `acc` equals the previous `acc` plus the R2 product, modulo 2^36.
- R6: The guard bits acc[35:31] extend the sign, so accumulated sums past 2^31 stay exact and wrap only at 2^36. After a cleared-mode operation the bits acc[35:31] are all equal.
- R7: If `start` is sampled high at rising edge k while the unit is idle, `done` is high for exactly the one cycle after edge k+2.
- R8: `acc` does not change from the cycle `done` rises until the second rising edge after the next accepted `start`.
- R9: `start` is ignored while an operation is in progress: the running result and the timing of `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| accumMode | input | 1 | 0: cleared result, 1: add to accumulator; sampled with start |
| opA | input | 16 | Signed narrow operand |
| opB | input | 32 | Wide operand: signed upper half, unsigned lower half |
| acc | output | 36 | Accumulator result |
| done | output | 1 | One-cycle strobe when the result is final |

## Verification
The assertions take for granted that `start` is judged only against the unit's own busy phase. They also assume that a cleared-mode product can never reach the guard bits, which is true because every 16x32 product fits in 32 signed bits. The stimulus drives `start` for exactly one cycle per operation, except in the deliberate busy-start case. It changes the operands only at the falling edge, so each sampled operand pair is the one the bench model uses.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } mmState_t;

  typedef struct packed {
    logic loadOps;   // capture operands
    logic stepLow;   // add aligned low partial product
    logic stepHigh;  // add high partial product
    logic freshBase; // low step starts from zero
  } mmStrobe_t;

endpackage

// File: rtl/mixmul_partial.sv
module mixmul_partial #(
  parameter int A_W = 16,
  parameter int H_W = 16
) (
  input  logic [A_W-1:0]     a,
  input  logic [H_W-1:0]     b,
  input  logic               bSigned,
  output logic [A_W+H_W-1:0] prod
);
  localparam int PW = A_W + H_W;

  logic [PW-1:0] aExt;
  logic [PW-1:0] bExt;
  logic          bTop;

  // An unsigned b is zero-extended. A signed b copies its top bit.
  assign bTop = bSigned & b[H_W-1];
  assign aExt = {{(PW-A_W){a[A_W-1]}}, a};
  assign bExt = {{(PW-H_W){bTop}}, b};

  // The exact product fits in PW signed bits, so modular arithmetic is exact.
  assign prod = $signed(aExt) * $signed(bExt);

endmodule

// File: rtl/mixmul_ctrl.sv
module mixmul_ctrl
  import mixmul_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      accumMode,
  output mmStrobe_t strobes,
  output logic      done
);
  mmState_t state;
  mmState_t stateNext;
  logic     freshReg;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_LOW;
      ST_LOW:  stateNext = ST_HIGH;
      ST_HIGH: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.loadOps   = (state == ST_IDLE) && start;
    strobes.stepLow   = (state == ST_LOW);
    strobes.stepHigh  = (state == ST_HIGH);
    strobes.freshBase = freshReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      freshReg <= 1'b1;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_HIGH);
      if (strobes.loadOps) freshReg <= ~accumMode;
    end
  end

endmodule

// File: rtl/mixmul_datapath.sv
module mixmul_datapath
  import mixmul_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 32,
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  mmStrobe_t        strobes,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [ACC_W-1:0] acc
);
  localparam int H_W = B_W / 2;
  localparam int PW  = A_W + H_W;

  logic [A_W-1:0]   aReg;
  logic [B_W-1:0]   bReg;
  logic [H_W-1:0]   mulB;
  logic [PW-1:0]    prod;
  logic [ACC_W-1:0] lowAligned;
  logic [ACC_W-1:0] highAligned;
  logic [ACC_W-1:0] base;

  // One multiplier serves both halves. The high step selects the signed upper half.
  assign mulB = strobes.stepHigh ? bReg[B_W-1:H_W] : bReg[H_W-1:0];

  mixmul_partial #(.A_W(A_W), .H_W(H_W)) u_mul (
    .a      (aReg),
    .b      (mulB),
    .bSigned(strobes.stepHigh),
    .prod   (prod)
  );

  // Low product: shifted right by H_W, sign preserved (floor).
  assign lowAligned  = {{(ACC_W-A_W){prod[PW-1]}}, prod[PW-1:H_W]};
  // High product: already at the weight of the result.
  assign highAligned = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign base        = strobes.freshBase ? '0 : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
      acc  <= '0;
    end else begin
      if (strobes.loadOps) begin
        aReg <= opA;
        bReg <= opB;
      end
      if (strobes.stepLow)
        acc <= base + lowAligned;
      else if (strobes.stepHigh)
        acc <= acc + highAligned;
    end
  end

endmodule

// File: rtl/mixmul_acc.sv
module mixmul_acc
  import mixmul_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 32,
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             accumMode,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  output logic [ACC_W-1:0] acc,
  output logic             done
);
  mmStrobe_t strobes;

  mixmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .accumMode(accumMode),
    .strobes  (strobes),
    .done     (done)
  );

  mixmul_datapath #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .acc    (acc)
  );

endmodule

// File: rtl/mixmul_acc_chk.sv
module mixmul_acc_chk #(
  parameter int A_W   = 16,
  parameter int B_W   = 32,
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             accumMode,
  input logic             done,
  input logic [ACC_W-1:0] acc
);
  localparam int PW = A_W + B_W / 2;

  // Independent model of the busy phase, built only from the port protocol.
  logic [1:0] phase;
  logic       modeLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 2'd0;
      modeLat <= 1'b0;
    end else begin
      case (phase)
        2'd0: if (start) begin phase <= 2'd1; modeLat <= accumMode; end
        2'd1: phase <= 2'd2;
        default: phase <= 2'd0;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |-> (acc == '0) && !done);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd2) |=> done);

  // R9
  done_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(phase) == 2'd2));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd0) |=> $stable(acc));

  // R6
  guard_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeLat) |-> ((acc[ACC_W-1:PW-1] == '0) || (acc[ACC_W-1:PW-1] == '1)));

endmodule

bind mixmul_acc mixmul_acc_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .accumMode(accumMode),
  .done     (done),
  .acc      (acc)
);

// File: tb/mixmul_acc_tb.sv
`timescale 1ns/1ps
module mixmul_acc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        accumMode = 1'b0;
  logic [15:0] opA = '0;
  logic [31:0] opB = '0;
  logic [35:0] acc;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [35:0] model = '0;

  always #10 clk = ~clk;

  mixmul_acc u_dut (
    .clk(clk), .rstN(rstN), .start(start), .accumMode(accumMode),
    .opA(opA), .opB(opB), .acc(acc), .done(done)
  );

  function automatic logic [35:0] prodOf(input logic [15:0] a, input logic [31:0] b);
    longint aS, hi, lo, r;
    aS = longint'($signed(a));
    hi = longint'($signed(b[31:16]));
    lo = longint'({1'b0, b[15:0]});
    r  = aS * hi + ((aS * lo) >>> 16);
    return r[35:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one operation. With intrude set, a second start with other
  // operands is driven while the unit is busy.
  task automatic runOp(input logic [15:0] a, input logic [31:0] b, input bit mode, input bit intrude);
    logic [35:0] exp;
    exp = mode ? model + prodOf(a, b) : prodOf(a, b);
    @(negedge clk);
    opA = a; opB = b; accumMode = mode; start = 1'b1;
    @(negedge clk);                      // edge k has passed
    if (intrude) begin
      opA = ~a; opB = ~b; accumMode = ~mode; start = 1'b1;
    end else start = 1'b0;
    @(negedge clk);                      // edge k+1
    start = 1'b0;
    check(done == 1'b0, "R7 early done", {35'd0, done}, 36'd0);
    @(negedge clk);                      // edge k+2
    check(done == 1'b1, "R7 done strobe", {35'd0, done}, 36'd1);
    check(acc == exp, intrude ? "R9 busy start" : (mode ? "R5 accumulate" : "R2 product"), acc, exp);
    model = exp;
    @(negedge clk);
    check(done == 1'b0, "R7 single pulse", {35'd0, done}, 36'd0);
    check(acc == exp, "R8 hold", acc, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] aSet [8];
    logic [31:0] bSet [10];
    aSet = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF, 16'h3039, 16'hEF1F};
    bSet = '{32'h0000_0000, 32'h0000_0001, 32'h0000_FFFF, 32'h0000_8000, 32'h7FFF_FFFF,
             32'h8000_0000, 32'hFFFF_FFFF, 32'h0001_0000, 32'h1234_8765, 32'hABCD_0001};

    repeat (3) @(negedge clk);
    check(acc == '0 && done == 1'b0, "R1 in reset", acc, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(acc == '0 && done == 1'b0, "R1 after reset", acc, '0);

    // R3: bit 15 of the low half counts as +32768
    runOp(16'd2, 32'h0000_8000, 1'b0, 1'b0);
    check(acc == 36'd1, "R3 unsigned low half", acc, 36'd1);
    // R4: floor of the shifted low product
    runOp(16'hFFFF, 32'h0000_0001, 1'b0, 1'b0);
    check(acc == 36'hF_FFFF_FFFF, "R4 arithmetic shift", acc, 36'hF_FFFF_FFFF);

    // R2 sweep over corner operand pairs
    foreach (aSet[i]) foreach (bSet[j]) runOp(aSet[i], bSet[j], 1'b0, 1'b0);

    // R8: acc stays put over idle cycles with start held low
    repeat (5) @(negedge clk);
    check(acc == model, "R8 idle hold", acc, model);

    // R9: start during busy is ignored
    runOp(16'h1234, 32'h5678_9ABC, 1'b0, 1'b1);

    // R5 mixed accumulation
    runOp(16'h8000, 32'hFFFF_7FFF, 1'b1, 1'b0);
    runOp(16'h0ABC, 32'h8001_FFFF, 1'b1, 1'b0);

    // R6: guard bits grow and wrap only at 2^36 (2^30 per step)
    runOp(16'h8000, 32'h8000_0000, 1'b0, 1'b0);
    for (int n = 2; n <= 40; n++) begin
      runOp(16'h8000, 32'h8000_0000, 1'b1, 1'b0);
      if (n == 4) check(acc == 36'h1_0000_0000, "R6 past 32 bits", acc, 36'h1_0000_0000);
      if (n == 32) check(acc == 36'h8_0000_0000, "R6 wrap at 36 bits", acc, 36'h8_0000_0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule